// File: doc/BRIEF.md
# Stack Frame Save/Restore Sequencer

This block moves stack frames between a small 8-bit CPU core and a byte-wide data memory. It owns the 16-bit stack pointer. It accepts one of six frame commands: three that save and three that restore. Each command comes with the values it needs: a return address, a status byte or a register pair. The block then runs the byte transfers one at a time on the memory port and leaves the pointer at its new top of stack.

Saves move the pointer down by one before each byte is written. Restores read the byte at the current pointer and then move it up by one. The interrupt frame is three bytes, with the status byte stored above the return address. Call and push frames are two bytes each. Restored values appear on dedicated outputs and stay there, marked by a single-cycle done strobe.

The pointer has no reset value, so software must load it directly before any stack traffic. An extra output flags every stack access whose address lies outside a parameterised internal-RAM window.

Top module: `stack_seq`

## Requirements
- R1: While and after reset, busy_o and done_o are low and no memory access is issued (mem_we_o and mem_re_o low, never both high). The stack pointer itself has no reset value.
- R2: With sp_load_i high while the block is idle, sp_o shows sp_data_i from the next cycle. A command accepted in the same cycle starts from the loaded value.
- R3: Command codes are 0 interrupt entry, 1 call, 2 push, 3 return-from-interrupt, 4 return and 5 pop. A command is accepted only when cmd_valid_i is high and busy_o is low. Codes 6 and 7 are ignored, and so is a command presented while busy.
- R4: Interrupt entry writes the status byte at SP-1, PC[15:8] at SP-2 and PC[7:0] at SP-3, in that order, and leaves SP-3.
- R5: Call writes PC[15:8] at SP-1 and then PC[7:0] at SP-2. Push writes pair[15:8] at SP-1 and then pair[7:0] at SP-2. Both leave SP-2.
- R6: Return-from-interrupt reads PC[7:0] at SP, PC[15:8] at SP+1 and the status byte at SP+2, in that order, and leaves SP+3.
- R7: Return reads PC[7:0] at SP and then PC[15:8] at SP+1. Pop reads pair[7:0] at SP and then pair[15:8] at SP+1. Both leave SP+2.
- R8: Writes follow the accept edge on consecutive cycles, one byte per cycle, and the pointer is decremented at each write. An n-byte save raises done_o n+1 cycles after the accept edge.
- R9: mem_rdata_i is taken one cycle after a read address is presented, and no new read is issued in that cycle. An n-byte restore raises done_o 2n+1 cycles after the accept edge.
- R10: done_o is high for exactly one cycle at the end of each command, and busy_o is low in that cycle. pc_o, psw_o and pair_o change only while a restore is running.
- R11: sp_load_i is ignored while busy_o is high.
- R12: Pointer arithmetic wraps modulo 2^16 in both directions.
- R13: range_err_o is high exactly in cycles where a memory access targets an address below RAM_LO or above RAM_HI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command request |
| cmd_i | input | 3 | Command code |
| pc_i | input | 16 | Return address to save |
| psw_i | input | 8 | Status byte to save |
| pair_i | input | 16 | Register pair to save |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle end-of-command strobe |
| pc_o | output | 16 | Restored return address |
| psw_o | output | 8 | Restored status byte |
| pair_o | output | 16 | Restored register pair |
| sp_load_i | input | 1 | Direct pointer load |
| sp_data_i | input | 16 | Value for direct load |
| sp_o | output | 16 | Current stack pointer |
| mem_addr_o | output | 16 | Memory byte address |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, one cycle after read |
| range_err_o | output | 1 | Access outside internal-RAM window |

## Verification
Each of the six commands is run against several pointer bases: 0x0000, 0x0001 and 0xFFFF, which exercise wrap in both directions, a mid-range value, and two values on the edges of the RAM window. The values saved are derived from the base, so that a swapped byte order, a wrong address offset or a wrong field shows up as a mismatch in the frame. Restores are checked against frames that the bench places itself in memory, which separates read ordering from write ordering. Separate runs offer reserved codes, commands that arrive while busy, pointer loads that arrive while busy, and a load that coincides with a command.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;
  localparam int unsigned SP_W   = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CMD_W  = 3;
  localparam int unsigned STEP_W = 2;
  localparam int unsigned NCMD   = 6;

  typedef enum logic [CMD_W-1:0] {
    CMD_INTR = 3'd0,
    CMD_CALL = 3'd1,
    CMD_PUSH = 3'd2,
    CMD_RETI = 3'd3,
    CMD_RET  = 3'd4,
    CMD_POP  = 3'd5
  } cmd_e;

  typedef enum logic [2:0] {
    FLD_PSW,
    FLD_PC_HI,
    FLD_PC_LO,
    FLD_PR_HI,
    FLD_PR_LO
  } fld_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_WAIT
  } st_e;

  function automatic logic cmd_known(input logic [CMD_W-1:0] c);
    return c < CMD_W'(NCMD);
  endfunction
endpackage

// File: rtl/stack_seq_plan.sv
// Per-command byte layout: which field moves at each step, direction, last step.
module stack_seq_plan
  import stack_seq_pkg::*;
(
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [STEP_W-1:0] step_i,
  output fld_e              fld_o,
  output logic              wr_o,
  output logic              last_o
);
  always_comb begin
    fld_o  = FLD_PC_LO;
    wr_o   = 1'b0;
    last_o = 1'b1;
    unique case (cmd_i)
      CMD_INTR: begin
        wr_o   = 1'b1;
        last_o = (step_i == STEP_W'(2));
        case (step_i)
          STEP_W'(0): fld_o = FLD_PSW;
          STEP_W'(1): fld_o = FLD_PC_HI;
          default:    fld_o = FLD_PC_LO;
        endcase
      end
      CMD_CALL: begin
        wr_o   = 1'b1;
        last_o = (step_i == STEP_W'(1));
        fld_o  = (step_i == STEP_W'(0)) ? FLD_PC_HI : FLD_PC_LO;
      end
      CMD_PUSH: begin
        wr_o   = 1'b1;
        last_o = (step_i == STEP_W'(1));
        fld_o  = (step_i == STEP_W'(0)) ? FLD_PR_HI : FLD_PR_LO;
      end
      CMD_RETI: begin
        last_o = (step_i == STEP_W'(2));
        case (step_i)
          STEP_W'(0): fld_o = FLD_PC_LO;
          STEP_W'(1): fld_o = FLD_PC_HI;
          default:    fld_o = FLD_PSW;
        endcase
      end
      CMD_RET: begin
        last_o = (step_i == STEP_W'(1));
        fld_o  = (step_i == STEP_W'(0)) ? FLD_PC_LO : FLD_PC_HI;
      end
      CMD_POP: begin
        last_o = (step_i == STEP_W'(1));
        fld_o  = (step_i == STEP_W'(0)) ? FLD_PR_LO : FLD_PR_HI;
      end
      default: begin
        fld_o  = FLD_PC_LO;
        wr_o   = 1'b0;
        last_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/stack_seq_ptr.sv
// Stack pointer: deliberately not reset, must be loaded before use.
module stack_seq_ptr
  import stack_seq_pkg::*;
(
  input  logic            clk_i,
  input  logic            ld_i,
  input  logic [SP_W-1:0] ld_val_i,
  input  logic            dec_i,
  input  logic            inc_i,
  output logic [SP_W-1:0] sp_o
);
  logic [SP_W-1:0] sp_q;

  always_ff @(posedge clk_i) begin
    if (ld_i)       sp_q <= ld_val_i;
    else if (dec_i) sp_q <= sp_q - SP_W'(1);
    else if (inc_i) sp_q <= sp_q + SP_W'(1);
  end

  assign sp_o = sp_q;
endmodule

// File: rtl/stack_seq_win.sv
module stack_seq_win
  import stack_seq_pkg::*;
#(
  parameter logic [SP_W-1:0] LO = 16'hFE00,
  parameter logic [SP_W-1:0] HI = 16'hFEFF
) (
  input  logic            act_i,
  input  logic [SP_W-1:0] addr_i,
  output logic            err_o
);
  assign err_o = act_i && ((addr_i < LO) || (addr_i > HI));
endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter logic [15:0] RAM_LO = 16'hFE00,
  parameter logic [15:0] RAM_HI = 16'hFEFF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_valid_i,
  input  logic [2:0]  cmd_i,
  input  logic [15:0] pc_i,
  input  logic [7:0]  psw_i,
  input  logic [15:0] pair_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] pc_o,
  output logic [7:0]  psw_o,
  output logic [15:0] pair_o,
  input  logic        sp_load_i,
  input  logic [15:0] sp_data_i,
  output logic [15:0] sp_o,
  output logic [15:0] mem_addr_o,
  output logic        mem_we_o,
  output logic        mem_re_o,
  output logic [7:0]  mem_wdata_o,
  input  logic [7:0]  mem_rdata_i,
  output logic        range_err_o
);
  st_e               state_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [STEP_W-1:0] step_q;
  logic [SP_W-1:0]   spc_q, spr_q;
  logic [BYTE_W-1:0] sps_q;
  logic [SP_W-1:0]   rpc_q, rpr_q;
  logic [BYTE_W-1:0] rps_q;
  logic              done_q;

  fld_e              fld;
  logic              wr, last;
  logic              accept, finish;
  logic [SP_W-1:0]   sp;

  assign accept = cmd_valid_i && (state_q == ST_IDLE) && cmd_known(cmd_i);

  stack_seq_plan i_plan (
    .cmd_i  (cmd_q),
    .step_i (step_q),
    .fld_o  (fld),
    .wr_o   (wr),
    .last_o (last)
  );

  assign mem_we_o = (state_q == ST_XFER) && wr;
  assign mem_re_o = (state_q == ST_XFER) && !wr;

  stack_seq_ptr i_ptr (
    .clk_i    (clk_i),
    .ld_i     (sp_load_i && (state_q == ST_IDLE)),
    .ld_val_i (sp_data_i),
    .dec_i    (mem_we_o),
    .inc_i    (mem_re_o),
    .sp_o     (sp)
  );

  // pre-decrement address on writes, current pointer on reads
  assign mem_addr_o = wr ? (sp - SP_W'(1)) : sp;

  always_comb begin
    unique case (fld)
      FLD_PSW:   mem_wdata_o = sps_q;
      FLD_PC_HI: mem_wdata_o = spc_q[15:8];
      FLD_PC_LO: mem_wdata_o = spc_q[7:0];
      FLD_PR_HI: mem_wdata_o = spr_q[15:8];
      default:   mem_wdata_o = spr_q[7:0];
    endcase
  end

  stack_seq_win #(.LO(RAM_LO), .HI(RAM_HI)) i_win (
    .act_i  (mem_we_o || mem_re_o),
    .addr_i (mem_addr_o),
    .err_o  (range_err_o)
  );

  assign finish = ((state_q == ST_XFER) && wr && last) ||
                  ((state_q == ST_WAIT) && last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      step_q  <= '0;
      spc_q   <= '0;
      spr_q   <= '0;
      sps_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_XFER;
            cmd_q   <= cmd_i;
            step_q  <= '0;
            spc_q   <= pc_i;
            sps_q   <= psw_i;
            spr_q   <= pair_i;
          end
        end
        ST_XFER: begin
          if (!wr)       state_q <= ST_WAIT;
          else if (last) state_q <= ST_IDLE;
          else           step_q  <= step_q + STEP_W'(1);
        end
        ST_WAIT: begin
          if (last) begin
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_XFER;
            step_q  <= step_q + STEP_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // restored values: only touched in the data-return cycle of a restore
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rpc_q <= '0;
      rps_q <= '0;
      rpr_q <= '0;
    end else if (state_q == ST_WAIT) begin
      unique case (fld)
        FLD_PSW:   rps_q        <= mem_rdata_i;
        FLD_PC_HI: rpc_q[15:8]  <= mem_rdata_i;
        FLD_PC_LO: rpc_q[7:0]   <= mem_rdata_i;
        FLD_PR_HI: rpr_q[15:8]  <= mem_rdata_i;
        default:   rpr_q[7:0]   <= mem_rdata_i;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign pc_o   = rpc_q;
  assign psw_o  = rps_q;
  assign pair_o = rpr_q;
  assign sp_o   = sp;
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_valid_i,
  input logic [2:0]  cmd_i,
  input logic        busy_o,
  input logic        done_o,
  input logic [15:0] pc_o,
  input logic [7:0]  psw_o,
  input logic [15:0] pair_o,
  input logic        sp_load_i,
  input logic [15:0] sp_o,
  input logic        mem_we_o,
  input logic        mem_re_o,
  input logic        range_err_o
);
  a_r1_excl_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  a_r3_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(mem_we_o || mem_re_o));

  a_r8_predec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (sp_o == $past(sp_o) - 16'd1));

  a_r9_postinc_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> ((sp_o == $past(sp_o) + 16'd1) && !mem_re_o));

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r10_hold_values: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> ($stable(pc_o) && $stable(psw_o) && $stable(pair_o)));

  a_r11_load_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mem_we_o && !mem_re_o) |=> $stable(sp_o));

  a_r13_err_on_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    range_err_o |-> (mem_we_o || mem_re_o));
endmodule

bind stack_seq stack_seq_chk i_stack_seq_chk (.*);

// File: tb/test_stack_seq.sv
module test_stack_seq;
  localparam int CLK_P = 10;
  localparam logic [15:0] LO = 16'hFE00;
  localparam logic [15:0] HI = 16'hFEFF;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [2:0]  cmd_i = '0;
  logic [15:0] pc_i = '0;
  logic [7:0]  psw_i = '0;
  logic [15:0] pair_i = '0;
  logic        busy_o, done_o;
  logic [15:0] pc_o, pair_o;
  logic [7:0]  psw_o;
  logic        sp_load_i = 1'b0;
  logic [15:0] sp_data_i = '0;
  logic [15:0] sp_o, mem_addr_o;
  logic        mem_we_o, mem_re_o, range_err_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i = '0;

  stack_seq #(.RAM_LO(LO), .RAM_HI(HI)) i_stack_seq (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  logic [7:0]  mem [256];
  logic [15:0] log_addr [16];
  logic        log_we [16];
  logic [7:0]  log_dat [16];
  int          log_n = 0;
  int          err_bad = 0, err_seen = 0;
  logic [15:0] model_sp;

  // memory model and access monitor
  always @(posedge clk_i) begin
    if (rst_ni && (mem_we_o || mem_re_o)) begin
      if (log_n < 16) begin
        log_addr[log_n] = mem_addr_o;
        log_we[log_n]   = mem_we_o;
        log_dat[log_n]  = mem_wdata_o;
      end
      log_n = log_n + 1;
      if (((mem_addr_o < LO) || (mem_addr_o > HI)) != range_err_o) err_bad++;
      if (range_err_o) err_seen++;
      if (mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
    end
    if (mem_re_o) mem_rdata_i <= mem[mem_addr_o[7:0]];
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic load_sp(input logic [15:0] v);
    @(negedge clk_i);
    sp_load_i = 1'b1; sp_data_i = v;
    @(negedge clk_i);
    sp_load_i = 1'b0;
    model_sp = v;
    chk(sp_o == v, "R2 direct load", sp_o, v);
  endtask

  task automatic exec(input logic [2:0] c, input logic [15:0] pc, input logic [7:0] ps, input logic [15:0] pr);
    logic [15:0] sp0, ea;
    logic [7:0]  eb [3];
    bit sv, ok;
    int n, cyc, ecyc;
    string rq;
    sp0 = model_sp;
    sv  = (c < 3);
    n   = (c == 0 || c == 3) ? 3 : 2;
    eb[2] = 8'h00;
    case (c)
      3'd0: begin eb[0] = ps; eb[1] = pc[15:8]; eb[2] = pc[7:0]; rq = "R4"; end
      3'd1: begin eb[0] = pc[15:8]; eb[1] = pc[7:0]; rq = "R5"; end
      3'd2: begin eb[0] = pr[15:8]; eb[1] = pr[7:0]; rq = "R5"; end
      3'd3: begin eb[0] = pc[7:0]; eb[1] = pc[15:8]; eb[2] = ps; rq = "R6"; end
      3'd4: begin eb[0] = pc[7:0]; eb[1] = pc[15:8]; rq = "R7"; end
      default: begin eb[0] = pr[7:0]; eb[1] = pr[15:8]; rq = "R7"; end
    endcase
    if (!sv) for (int k = 0; k < n; k++) mem[8'(sp0 + 16'(k))] = eb[k];
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_i = c; pc_i = pc; psw_i = ps; pair_i = pr;
    log_n = 0;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    cyc = 1;
    while (!done_o && cyc < 100) begin
      @(negedge clk_i);
      cyc++;
    end
    ok = (log_n == n);
    for (int k = 0; k < n; k++) begin
      ea = sv ? (sp0 - 16'(k) - 16'd1) : (sp0 + 16'(k));
      if (log_addr[k] != ea || log_we[k] != sv) ok = 1'b0;
      if (sv && log_dat[k] != eb[k]) ok = 1'b0;
    end
    chk(ok, {rq, " frame layout"}, log_n, n);
    ecyc = sv ? n + 1 : 2 * n + 1;
    chk(cyc == ecyc, sv ? "R8 save timing" : "R9 restore timing", cyc, ecyc);
    model_sp = sv ? sp0 - 16'(n) : sp0 + 16'(n);
    chk(sp_o == model_sp, {rq, " R12 final sp"}, sp_o, model_sp);
    case (c)
      3'd3: chk({pc_o, psw_o} == {pc, ps}, "R6 restored pc/psw", {pc_o, psw_o}, {pc, ps});
      3'd4: chk(pc_o == pc, "R7 restored pc", pc_o, pc);
      3'd5: chk(pair_o == pr, "R7 restored pair", pair_o, pr);
      default: ;
    endcase
    @(negedge clk_i);
    chk(!done_o, "R10 done single cycle", done_o, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] b, pcv, prv, hold;
    logic [7:0]  psv;
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !mem_we_o && !mem_re_o, "R1 in reset", {busy_o, done_o, mem_we_o, mem_re_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!busy_o && !done_o && !mem_we_o && !mem_re_o, "R1 after reset", {busy_o, done_o, mem_we_o, mem_re_o}, 0);

    // sweep bases over every command
    for (int i = 0; i < 6; i++) begin
      case (i)
        0: b = 16'hFF00;
        1: b = 16'hFE02;
        2: b = 16'h0001;
        3: b = 16'h0000;
        4: b = 16'hFFFF;
        default: b = 16'h8000;
      endcase
      pcv = b ^ 16'hA55A;
      psv = b[7:0] ^ 8'h3C;
      prv = {b[7:0], b[15:8]} ^ 16'h1EE7;
      load_sp(b);
      exec(3'd0, pcv, psv, prv);
      exec(3'd3, pcv, psv, prv);
      exec(3'd1, pcv + 16'd1, psv, prv);
      exec(3'd4, pcv ^ 16'h0F0F, psv, prv);
      exec(3'd2, pcv, psv, prv);
      exec(3'd5, pcv, psv, prv ^ 16'hF00F);
    end

    // R10: a save leaves restored outputs untouched
    load_sp(16'hFE80);
    exec(3'd4, 16'h1234, 8'h00, 16'h0);
    hold = pc_o;
    exec(3'd1, 16'hBEEF, 8'h00, 16'h0);
    chk(pc_o == hold, "R10 pc_o held across save", pc_o, hold);

    // R3: reserved codes ignored
    for (int c = 6; c < 8; c++) begin
      @(negedge clk_i);
      cmd_valid_i = 1'b1; cmd_i = 3'(c);
      log_n = 0;
      @(negedge clk_i);
      cmd_valid_i = 1'b0;
      repeat (3) @(negedge clk_i);
      chk(!busy_o && log_n == 0 && sp_o == model_sp, "R3 reserved code ignored", log_n, 0);
    end

    // R3/R11: command and load while busy ignored
    load_sp(16'hFE40);
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_i = 3'd2; pair_i = 16'h5AA5;
    log_n = 0;
    @(negedge clk_i);
    cmd_i = 3'd1; sp_load_i = 1'b1; sp_data_i = 16'h1234;
    while (!done_o) @(negedge clk_i);
    cmd_valid_i = 1'b0; sp_load_i = 1'b0;
    chk(sp_o == 16'hFE3E, "R11 load ignored while busy", sp_o, 16'hFE3E);
    repeat (3) @(negedge clk_i);
    chk(log_n == 2 && !busy_o, "R3 command while busy ignored", log_n, 2);
    chk(mem[8'h3F] == 8'h5A && mem[8'h3E] == 8'hA5, "R5 push bytes", {mem[8'h3F], mem[8'h3E]}, 16'h5AA5);

    // R2: load and command in the same cycle
    @(negedge clk_i);
    sp_load_i = 1'b1; sp_data_i = 16'hFE20;
    cmd_valid_i = 1'b1; cmd_i = 3'd2; pair_i = 16'hC33C;
    log_n = 0;
    @(negedge clk_i);
    sp_load_i = 1'b0; cmd_valid_i = 1'b0;
    while (!done_o) @(negedge clk_i);
    chk(log_n == 2 && log_addr[0] == 16'hFE1F && log_addr[1] == 16'hFE1E, "R2 load with command", log_addr[0], 16'hFE1F);
    chk(sp_o == 16'hFE1E, "R2 sp after combined start", sp_o, 16'hFE1E);

    chk(err_bad == 0, "R13 range flag mismatches", err_bad, 0);
    chk(err_seen > 0, "R13 range flag exercised", err_seen, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule